// File: doc/BRIEF.md
# Proportional-Integral Timing Loop Filter

This block sits between a timing-error detector and whatever moves the sampling instant, such as a phase selector, an interpolator control or a numerically controlled oscillator. Once per symbol the detector presents a signed error sample with a strobe. The block scales the sample by an arithmetic right shift to form a proportional term. It scales the sample by a second, independent shift and adds it into a saturating integrator. The control word it registers is the proportional term plus the freshly updated integrator, clamped to the word width. Two sign flags tell the controller whether to move the sampling instant earlier or later.

The integral path lets the loop follow a constant sample-clock rate mismatch of up to about 100 ppm between the two ends of the link. In steady state the integrator holds the rate correction and the proportional path removes residual phase. A loop-open input breaks the loop for measurement. While it is high the integrator is frozen and the control word is forced to zero, so no correction reaches the sampler. This lets open-loop and closed-loop tracking be compared on the same error stream.

Top module: `tim_loop_pi`

## Requirements
- R1: While `rst_n` is low, `ctl_o`, `ctl_vld_o`, `adv_o` and `ret_o` are zero and the integrator is cleared. The first closed-loop update after reset with a zero error gives `ctl_o == 0`.
- R2: With `open_loop_i` low, the clock edge that samples `err_vld_i` high sets the integrator I to sat(I + (err >>> ki)). The same edge sets `ctl_o` to sat((err >>> kp) + I), using the new I.
- R3: The integrator clamps at +2^(ACC_W-1)-1 and -2^(ACC_W-1) and never wraps past either limit.
- R4: The sum that forms `ctl_o` is clamped to the same signed limits.
- R5: When `err_vld_i` is low and `open_loop_i` is low, `ctl_o`, the sign flags and the integrator hold their values whatever `err_i` carries.
- R6: On every clock edge that samples `open_loop_i` high, the integrator holds and `ctl_o` becomes zero. After the loop closes again, the next valid error resumes from the held integrator value.
- R7: `adv_o` is 1 exactly when `ctl_o` is greater than zero. `ret_o` is 1 exactly when `ctl_o` is less than zero. Both are 0 when `ctl_o` is zero.
- R8: `kp_i` and `ki_i` are unsigned shift counts from 0 to 15. Each shift is arithmetic, so it rounds toward minus infinity; for example, -1 >>> 1 is -1 and 5 >>> 3 is 0.
- R9: `ctl_vld_o` is high for exactly the cycle after each cycle in which `err_vld_i` is high, in both loop modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| err_vld_i | input | 1 | Error sample strobe |
| err_i | input | ERR_W (16) | Signed timing error |
| kp_i | input | GAIN_W (4) | Proportional right-shift count |
| ki_i | input | GAIN_W (4) | Integral right-shift count |
| open_loop_i | input | 1 | 1 = loop broken, integrator frozen, control forced to zero |
| ctl_vld_o | output | 1 | Control word updated this cycle |
| ctl_o | output | ACC_W (24) | Signed control word |
| adv_o | output | 1 | Control word positive: advance sampling instant |
| ret_o | output | 1 | Control word negative: retard sampling instant |

## Verification
The control word, the sign flags and the update strobe each pass through a single register. They are all due on the clock edge that samples the error strobe. Forcing the word to zero in open-loop mode also takes effect on the first edge that samples the open input. The bench drives inputs on falling edges and reads outputs on the next falling edge, half a period after the capturing edge. In that sampling window the value it checks is the one computed from the stimulus just applied. The hold checks idle for several such windows with a changing error input and confirm nothing moved.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
  // Loop mode as seen by the control register.
  typedef enum logic [1:0] {
    TLF_HOLD   = 2'd0,
    TLF_UPDATE = 2'd1,
    TLF_OPEN   = 2'd2
  } tlf_mode_e;

  function automatic tlf_mode_e tlf_mode(input logic vld, input logic open_loop);
    if (open_loop)  return TLF_OPEN;
    else if (vld)   return TLF_UPDATE;
    else            return TLF_HOLD;
  endfunction
endpackage

// File: rtl/tlf_ashr.sv
// Sign-extend an input word to the output width, then shift right arithmetically.
module tlf_ashr #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 24,
  parameter int SH_W  = 4
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SH_W-1:0]  sh,
  output logic [OUT_W-1:0] dout
);
  logic [OUT_W-1:0] ext;

  generate
    if (OUT_W > IN_W) begin : g_ext
      assign ext = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
    end else begin : g_same
      assign ext = din[OUT_W-1:0];
    end
  endgenerate

  assign dout = $unsigned($signed(ext) >>> sh);
endmodule

// File: rtl/tlf_sat_add.sv
// Signed adder that clamps to the W-bit limits instead of wrapping.
module tlf_sat_add #(
  parameter int W = 24
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         clipped
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W:0] wide;

  always_comb begin
    wide    = {a[W-1], a} + {b[W-1], b};
    clipped = wide[W] ^ wide[W-1];
    if (!clipped)     y = wide[W-1:0];
    else if (wide[W]) y = NEG_LIM;
    else              y = POS_LIM;
  end

  // R3/R4: operands of equal sign never give a result of the other sign
  always_comb begin
    if (a[W-1] == b[W-1]) begin
      assert_no_wrap_R3: assert (y[W-1] == a[W-1]);
    end
  end
endmodule

// File: rtl/tlf_integ.sv
// Integrator state register with an explicit clock enable.
module tlf_integ #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/tim_loop_pi.sv
module tim_loop_pi
  import tlf_pkg::*;
#(
  parameter int ERR_W  = 16,
  parameter int ACC_W  = 24,
  parameter int GAIN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_vld_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic [GAIN_W-1:0] kp_i,
  input  logic [GAIN_W-1:0] ki_i,
  input  logic              open_loop_i,
  output logic              ctl_vld_o,
  output logic [ACC_W-1:0]  ctl_o,
  output logic              adv_o,
  output logic              ret_o
);
  localparam logic [ACC_W-1:0] ZERO_W = '0;

  tlf_mode_e        mode;
  logic [ACC_W-1:0] prop_term, int_term;
  logic [ACC_W-1:0] integ_q, integ_sum, ctl_sum;
  logic             integ_clip, ctl_clip;
  logic             integ_en;

  logic [ACC_W-1:0] ctl_next;
  logic             adv_next, ret_next, vld_next, ctl_en;

  assign mode = tlf_mode(err_vld_i, open_loop_i);

  tlf_ashr #(.IN_W(ERR_W), .OUT_W(ACC_W), .SH_W(GAIN_W)) u_prop_shift (
    .din(err_i), .sh(kp_i), .dout(prop_term)
  );

  tlf_ashr #(.IN_W(ERR_W), .OUT_W(ACC_W), .SH_W(GAIN_W)) u_int_shift (
    .din(err_i), .sh(ki_i), .dout(int_term)
  );

  tlf_sat_add #(.W(ACC_W)) u_int_add (
    .a(integ_q), .b(int_term), .y(integ_sum), .clipped(integ_clip)
  );

  assign integ_en = (mode == TLF_UPDATE);

  tlf_integ #(.W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(integ_en), .d(integ_sum), .q(integ_q)
  );

  tlf_sat_add #(.W(ACC_W)) u_ctl_add (
    .a(prop_term), .b(integ_sum), .y(ctl_sum), .clipped(ctl_clip)
  );

  // Next-state for the control register
  always_comb begin
    ctl_en   = (mode != TLF_HOLD);
    ctl_next = ctl_o;
    adv_next = adv_o;
    ret_next = ret_o;
    vld_next = err_vld_i;
    case (mode)
      TLF_UPDATE: begin
        ctl_next = ctl_sum;
        ret_next = ctl_sum[ACC_W-1];
        adv_next = !ctl_sum[ACC_W-1] && (ctl_sum != ZERO_W);
      end
      TLF_OPEN: begin
        ctl_next = ZERO_W;
        ret_next = 1'b0;
        adv_next = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_o     <= '0;
      adv_o     <= 1'b0;
      ret_o     <= 1'b0;
      ctl_vld_o <= 1'b0;
    end else begin
      ctl_vld_o <= vld_next;
      if (ctl_en) begin
        ctl_o <= ctl_next;
        adv_o <= adv_next;
        ret_o <= ret_next;
      end
    end
  end

  // R6: open loop freezes the integrator and zeroes the control word
  assert_open_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    open_loop_i |=> ($stable(integ_q) && (ctl_o == ZERO_W)));

  // R5: no strobe and closed loop keeps the control word
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_vld_i && !open_loop_i) |=> ($stable(ctl_o) && $stable(integ_q)));

  // R9: update strobe follows the error strobe by one cycle
  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld_i |=> ctl_vld_o);
  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld_i |=> !ctl_vld_o);

  // R7: direction flags agree with the control word's sign
  assert_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv_o && ret_o) && (adv_o == ($signed(ctl_o) > 0)) && (ret_o == ($signed(ctl_o) < 0)));

  // R3: a non-negative integrator fed a non-negative term stays non-negative
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_en && !integ_q[ACC_W-1] && !err_i[ERR_W-1]) |=> !integ_q[ACC_W-1]);
endmodule

// File: tb/tim_loop_pi_tb.sv
module tim_loop_pi_tb;
  localparam int ERR_W  = 16;
  localparam int ACC_W  = 24;
  localparam int GAIN_W = 4;
  localparam longint LIM_P = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint LIM_N = -(64'sd1 <<< (ACC_W-1));

  // {err, kp, ki, open}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {16'h03E8, 4'd2,  4'd3,  1'b0},
    {16'hFC18, 4'd0,  4'd4,  1'b0},
    {16'h7FFF, 4'd15, 4'd15, 1'b0},
    {16'h8000, 4'd15, 4'd0,  1'b0},
    {16'hFFFF, 4'd1,  4'd1,  1'b0},
    {16'h0005, 4'd3,  4'd3,  1'b0},
    {16'h01F4, 4'd0,  4'd0,  1'b1},
    {16'hFD44, 4'd0,  4'd0,  1'b1},
    {16'h007B, 4'd0,  4'd0,  1'b0},
    {16'hB1E0, 4'd1,  4'd2,  1'b0},
    {16'h0007, 4'd0,  4'd15, 1'b0},
    {16'h4000, 4'd4,  4'd4,  1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              err_vld_i = 1'b0;
  logic [ERR_W-1:0]  err_i = '0;
  logic [GAIN_W-1:0] kp_i = '0;
  logic [GAIN_W-1:0] ki_i = '0;
  logic              open_loop_i = 1'b0;
  logic              ctl_vld_o;
  logic [ACC_W-1:0]  ctl_o;
  logic              adv_o, ret_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  longint m_int = 0;
  longint m_out = 0;

  tim_loop_pi #(.ERR_W(ERR_W), .ACC_W(ACC_W), .GAIN_W(GAIN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_vld_i(err_vld_i), .err_i(err_i),
    .kp_i(kp_i), .ki_i(ki_i), .open_loop_i(open_loop_i),
    .ctl_vld_o(ctl_vld_o), .ctl_o(ctl_o), .adv_o(adv_o), .ret_o(ret_o)
  );

  always #10 clk = ~clk;

  function automatic longint clampv(input longint v);
    if (v > LIM_P) return LIM_P;
    if (v < LIM_N) return LIM_N;
    return v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic vld_exp);
    chk(req, longint'($signed(ctl_o)), m_out);
    chk({req, "/R7 adv"}, longint'(adv_o), longint'(m_out > 0));
    chk({req, "/R7 ret"}, longint'(ret_o), longint'(m_out < 0));
    chk({req, "/R9 vld"}, longint'(ctl_vld_o), longint'(vld_exp));
  endtask

  // Apply one strobed error; outputs are due at the capturing edge.
  task automatic apply(input logic [15:0] e, input logic [3:0] kp,
                       input logic [3:0] ki, input logic op, input string req);
    longint ev;
    @(negedge clk);
    err_i = e; kp_i = kp; ki_i = ki; open_loop_i = op; err_vld_i = 1'b1;
    ev = longint'($signed(e));
    if (op) m_out = 0;
    else begin
      m_int = clampv(m_int + (ev >>> ki));
      m_out = clampv((ev >>> kp) + m_int);
    end
    @(negedge clk);
    err_vld_i = 1'b0;
    chk_out(req, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 ctl", longint'($signed(ctl_o)), 0);
    chk("R1 vld", longint'(ctl_vld_o), 0);
    chk("R1 adv", longint'(adv_o), 0);
    chk("R1 ret", longint'(ret_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R6/R8: vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][24:9], VEC[i][8:5], VEC[i][4:1], VEC[i][0], "R2 vec");
    end

    // R5: idle with a moving error input
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      err_i = 16'(i * 3001);
      chk_out("R5 idle", 1'b0);
    end

    // R8: rounding toward minus infinity
    apply(16'hFFFF, 4'd1, 4'd15, 1'b0, "R8 neg shift");
    apply(16'h0005, 4'd3, 4'd15, 1'b0, "R8 pos shift");

    // R6: open without strobe zeroes output, integrator resumes after close
    apply(16'h2000, 4'd0, 4'd0, 1'b0, "R2 prime");
    @(negedge clk);
    open_loop_i = 1'b1;
    @(negedge clk);
    m_out = 0;
    chk_out("R6 open zero", 1'b0);
    open_loop_i = 1'b0;
    @(negedge clk);
    chk_out("R6 stays zero", 1'b0);
    apply(16'h0000, 4'd0, 4'd0, 1'b0, "R6 resume");

    // R3/R4: drive into positive then negative saturation
    for (int i = 0; i < 300; i++) apply(16'h7FFF, 4'd0, 4'd0, 1'b0, "R3 pos sat");
    chk("R4 pos limit", longint'($signed(ctl_o)), LIM_P);
    for (int i = 0; i < 600; i++) apply(16'h8000, 4'd0, 4'd0, 1'b0, "R3 neg sat");
    chk("R4 neg limit", longint'($signed(ctl_o)), LIM_N);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async ctl", longint'($signed(ctl_o)), 0);
    chk("R1 async ret", longint'(ret_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_int = 0; m_out = 0;
    apply(16'h0000, 4'd0, 4'd0, 1'b0, "R1 cleared integ");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule